// File: doc/BRIEF.md
# Character-Clock Raster Timing Generator

This block produces the horizontal and vertical raster timing for a display controller that follows the classic character-clock CRT register model. Each clock is one character clock, meaning one group of 8 pixels. A line counter advances at the end of every horizontal line. A byte-wide write port loads a bank of timing registers. Most values are offset-encoded, and several vertical values are split across overflow bytes. The block decodes those bytes into full-width timing values. From them it drives horizontal and vertical sync, horizontal and vertical blank, a display-enable strobe, a retrace status bit and a line-compare strobe.

Writes land in a shadow bank right away. The counters, however, run from an active copy that is loaded only at the last character of the last line of a frame. A shortened total therefore never strands a counter past its end. Sync end and blank end are matched against truncated low bits of the counters, so pulse widths wrap modulo a power of two. A protect bit stops writes to the horizontal registers and to the overflow byte.

Top module: `crt_raster_gen`

## Requirements
- R1: After synchronous reset, both counters are at zero and the default timing is active. The defaults give a 16-character line, 10 visible characters and a 12-line frame. On the first cycle out of reset, hsync, vsync, hblank, vblank, line_cmp and vretrace are low and disp_en is high.
- R2: A line lasts (index 0 value + 5) character clocks.
- R3: disp_en is high while the character count is at most the index 1 value and the line count is at most the vertical display end. The vertical display end is built from index 11, plus bit 1 and bit 6 of index 7 as bits 8 and 9, plus bit 1 of index 15 as bit 10.
- R4: The hsync pulse starts on the character after the count equals index 4. It ends after the first character whose low 5 count bits equal bits 4:0 of index 5. Within one line the width is (end − start) mod 32, and a width of 0 becomes 32.
- R5: The hblank pulse starts on the character after the count equals index 2. It ends after the character whose low 6 count bits equal a 6-bit end value. Bits 4:0 of that value come from index 3, and bit 5 comes from bit 7 of index 5.
- R6: A frame lasts (vertical total + 2) lines. The vertical total is built from index 6, plus bit 0 and bit 5 of index 7 as bits 8 and 9, plus bit 0 of index 15 as bit 10.
- R7: vsync is active from the line after the line count equals the vertical sync start. It stays active through the first line whose low 4 count bits equal bits 3:0 of index 10. The vertical sync start is built from index 9, plus bits 2 and 7 of index 7 as bits 8 and 9, plus bit 3 of index 15 as bit 10.
- R8: vblank is active from the line after the vertical blank start. It stays active through the line whose low 8 count bits equal index 13. The vertical blank start is built from index 12, plus bit 3 of index 7, bit 5 of index 8 and bit 2 of index 15 as bits 8, 9 and 10.
- R9: line_cmp is a one-character pulse on character 0 of the line whose count equals the line-compare value. That value is built from index 14, plus bit 4 of index 7 and bit 6 of index 8 as bits 8 and 9. If the value is never reached, no pulse occurs.
- R10: When bit 6 of index 16 is set, the hsync pin is inverted (active low). When bit 7 of index 16 is set, the vsync pin is inverted.
- R11: vretrace is high exactly while vertical sync is active, whatever the vsync polarity.
- R12: While bit 7 of index 10 is set, writes to indices 0 to 7 are ignored. Writes to indices 8 and above still take effect.
- R13: A register write changes the timing only from the start of the frame after the write. The current frame keeps its old timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register index |
| wr_data | input | 8 | Register write data |
| hsync | output | 1 | Horizontal sync pin, polarity per index 16 bit 6 |
| vsync | output | 1 | Vertical sync pin, polarity per index 16 bit 7 |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| disp_en | output | 1 | Display enable |
| vretrace | output | 1 | Vertical retrace status |
| line_cmp | output | 1 | Line-compare pulse |

## Verification
The hardest case to reach from the ports is the full-width wrap of the truncated end compare, where the end field equals the start field's low bits. A 32-character hsync only fits in a line longer than 32 characters. A 16-line vsync only fits in a frame longer than 16 lines. The stimulus therefore first reprograms the total, then waits through two frame boundaries for the deferred load, and only then measures the pulse. The deferred load is itself checked by writing a larger total just after vsync rises and measuring a line that is still in the old frame.

// File: rtl/crt_pkg.sv
package crt_pkg;

    localparam int REG_W      = 8;
    localparam int NREGS      = 17;
    localparam int IDX_W      = 5;
    localparam int PROT_LIMIT = 8;
    localparam int HC_W       = 9;
    localparam int VC_W       = 12;
    localparam int VV_W       = 11;
    localparam int HSE_W      = 5;
    localparam int HBE_W      = 6;
    localparam int VSE_W      = 4;
    localparam int VBE_W      = 8;
    localparam int LC_W       = 10;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREGS - 1);
    localparam logic [IDX_W-1:0] PROT_TOP = IDX_W'(PROT_LIMIT - 1);

    typedef enum logic [IDX_W-1:0] {
        IX_HTOT    = 5'd0,
        IX_HDISP   = 5'd1,
        IX_HBSTART = 5'd2,
        IX_HBEND   = 5'd3,
        IX_HSSTART = 5'd4,
        IX_HSEND   = 5'd5,
        IX_VTOT    = 5'd6,
        IX_OVF     = 5'd7,
        IX_MAXSCAN = 5'd8,
        IX_VSSTART = 5'd9,
        IX_VSEND   = 5'd10,
        IX_VDISP   = 5'd11,
        IX_VBSTART = 5'd12,
        IX_VBEND   = 5'd13,
        IX_LCMP    = 5'd14,
        IX_VEXT    = 5'd15,
        IX_MISC    = 5'd16
    } reg_idx_e;

    typedef logic [NREGS-1:0][REG_W-1:0] reg_file_t;

    typedef struct packed {
        logic [REG_W-1:0] h_total;
        logic [REG_W-1:0] h_disp;
        logic [REG_W-1:0] h_blank_start;
        logic [HBE_W-1:0] h_blank_end;
        logic [REG_W-1:0] h_sync_start;
        logic [HSE_W-1:0] h_sync_end;
        logic [VV_W-1:0]  v_total;
        logic [VV_W-1:0]  v_disp;
        logic [VV_W-1:0]  v_blank_start;
        logic [VBE_W-1:0] v_blank_end;
        logic [VV_W-1:0]  v_sync_start;
        logic [VSE_W-1:0] v_sync_end;
        logic [LC_W-1:0]  line_cmp;
        logic             hs_neg;
        logic             vs_neg;
    } crt_cfg_t;

    // Power-on register bank: short 16x12 raster for quick turnaround.
    function automatic reg_file_t reset_regs();
        reg_file_t r;
        r = '0;
        r[IX_HTOT]    = 8'd11;
        r[IX_HDISP]   = 8'd9;
        r[IX_HBSTART] = 8'd9;
        r[IX_HBEND]   = 8'd15;
        r[IX_HSSTART] = 8'd11;
        r[IX_HSEND]   = 8'd13;
        r[IX_VTOT]    = 8'd10;
        r[IX_VSSTART] = 8'd8;
        r[IX_VSEND]   = 8'd9;
        r[IX_VDISP]   = 8'd7;
        r[IX_VBSTART] = 8'd7;
        r[IX_VBEND]   = 8'd11;
        r[IX_LCMP]    = 8'd8;
        return r;
    endfunction

    // Gather split fields into full-width timing values.
    function automatic crt_cfg_t decode_regs(reg_file_t r);
        crt_cfg_t c;
        c.h_total       = r[IX_HTOT];
        c.h_disp        = r[IX_HDISP];
        c.h_blank_start = r[IX_HBSTART];
        c.h_blank_end   = {r[IX_HSEND][7], r[IX_HBEND][4:0]};
        c.h_sync_start  = r[IX_HSSTART];
        c.h_sync_end    = r[IX_HSEND][4:0];
        c.v_total       = {r[IX_VEXT][0], r[IX_OVF][5], r[IX_OVF][0], r[IX_VTOT]};
        c.v_disp        = {r[IX_VEXT][1], r[IX_OVF][6], r[IX_OVF][1], r[IX_VDISP]};
        c.v_blank_start = {r[IX_VEXT][2], r[IX_MAXSCAN][5], r[IX_OVF][3], r[IX_VBSTART]};
        c.v_blank_end   = r[IX_VBEND];
        c.v_sync_start  = {r[IX_VEXT][3], r[IX_OVF][7], r[IX_OVF][2], r[IX_VSSTART]};
        c.v_sync_end    = r[IX_VSEND][3:0];
        c.line_cmp      = {r[IX_MAXSCAN][6], r[IX_OVF][4], r[IX_LCMP]};
        c.hs_neg        = r[IX_MISC][6];
        c.vs_neg        = r[IX_MISC][7];
        return c;
    endfunction

endpackage

// File: rtl/crt_reg_bank.sv
module crt_reg_bank
    import crt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                frame_end,
    output crt_cfg_t            cfg
);

    reg_file_t shadow;
    logic      protect;
    logic      wr_ok;

    assign protect = shadow[IX_VSEND][7];
    assign wr_ok   = wr_en && (wr_idx <= LAST_IDX) && !(protect && (wr_idx <= PROT_TOP));

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= reset_regs();
        end else if (wr_ok) begin
            shadow[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= decode_regs(reset_regs());
        end else if (frame_end) begin
            cfg <= decode_regs(shadow);
        end
    end

    // R12
    wp_block_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && protect && (wr_idx <= PROT_TOP)) |=>
            (shadow[$past(wr_idx)] == $past(shadow[wr_idx])));

    // R13
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(cfg));

endmodule

// File: rtl/crt_h_timer.sv
module crt_h_timer
    import crt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  crt_cfg_t         cfg,
    output logic [HC_W-1:0]  hcnt,
    output logic             line_end,
    output logic             hs_act,
    output logic             hb_act,
    output logic             h_disp_on
);

    logic [HC_W-1:0] ht_last;

    assign ht_last   = {1'b0, cfg.h_total} + HC_W'(4);
    assign line_end  = (hcnt == ht_last);
    assign h_disp_on = (hcnt <= {1'b0, cfg.h_disp});

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt   <= '0;
            hs_act <= 1'b0;
            hb_act <= 1'b0;
        end else begin
            hcnt <= line_end ? '0 : hcnt + HC_W'(1);
            if (hcnt == {1'b0, cfg.h_sync_start})
                hs_act <= 1'b1;
            else if (hcnt[HSE_W-1:0] == cfg.h_sync_end)
                hs_act <= 1'b0;
            if (hcnt == {1'b0, cfg.h_blank_start})
                hb_act <= 1'b1;
            else if (hcnt[HBE_W-1:0] == cfg.h_blank_end)
                hb_act <= 1'b0;
        end
    end

    // R4
    hs_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_act) |-> ($past(hcnt[HSE_W-1:0]) == $past(cfg.h_sync_end)));

    // R5
    hb_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hb_act) |-> ($past(hcnt[HBE_W-1:0]) == $past(cfg.h_blank_end)));

endmodule

// File: rtl/crt_v_timer.sv
module crt_v_timer
    import crt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  crt_cfg_t         cfg,
    input  logic             line_end,
    input  logic             line_start,
    output logic             frame_end,
    output logic             vs_act,
    output logic             vb_act,
    output logic             v_disp_on,
    output logic             lc_pulse
);

    logic [VC_W-1:0] vcnt;
    logic [VC_W-1:0] vt_last;

    assign vt_last   = {1'b0, cfg.v_total} + VC_W'(1);
    assign frame_end = line_end && (vcnt == vt_last);
    assign v_disp_on = (vcnt <= {1'b0, cfg.v_disp});
    assign lc_pulse  = line_start && (vcnt == {{(VC_W-LC_W){1'b0}}, cfg.line_cmp});

    always_ff @(posedge clk) begin
        if (rst) begin
            vcnt   <= '0;
            vs_act <= 1'b0;
            vb_act <= 1'b0;
        end else if (line_end) begin
            vcnt <= frame_end ? '0 : vcnt + VC_W'(1);
            if (vcnt == {1'b0, cfg.v_sync_start})
                vs_act <= 1'b1;
            else if (vcnt[VSE_W-1:0] == cfg.v_sync_end)
                vs_act <= 1'b0;
            if (vcnt == {1'b0, cfg.v_blank_start})
                vb_act <= 1'b1;
            else if (vcnt[VBE_W-1:0] == cfg.v_blank_end)
                vb_act <= 1'b0;
        end
    end

    // R7
    vs_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vs_act) |-> ($past(vcnt[VSE_W-1:0]) == $past(cfg.v_sync_end)));

    // R9
    lc_single_chk: assert property (@(posedge clk) disable iff (rst)
        lc_pulse |=> !lc_pulse);

    // R6
    vcnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        vcnt <= vt_last);

endmodule

// File: rtl/crt_raster_gen.sv
module crt_raster_gen
    import crt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [4:0]         wr_idx,
    input  logic [7:0]         wr_data,
    output logic               hsync,
    output logic               vsync,
    output logic               hblank,
    output logic               vblank,
    output logic               disp_en,
    output logic               vretrace,
    output logic               line_cmp
);

    crt_cfg_t        cfg;
    logic [HC_W-1:0] hcnt;
    logic            line_end, frame_end;
    logic            hs_act, hb_act, h_disp_on;
    logic            vs_act, vb_act, v_disp_on;

    crt_reg_bank u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .frame_end (frame_end),
        .cfg       (cfg)
    );

    crt_h_timer u_h (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .hcnt      (hcnt),
        .line_end  (line_end),
        .hs_act    (hs_act),
        .hb_act    (hb_act),
        .h_disp_on (h_disp_on)
    );

    crt_v_timer u_v (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .line_end   (line_end),
        .line_start (hcnt == '0),
        .frame_end  (frame_end),
        .vs_act     (vs_act),
        .vb_act     (vb_act),
        .v_disp_on  (v_disp_on),
        .lc_pulse   (line_cmp)
    );

    assign hsync    = hs_act ^ cfg.hs_neg;
    assign vsync    = vs_act ^ cfg.vs_neg;
    assign hblank   = hb_act;
    assign vblank   = vb_act;
    assign disp_en  = h_disp_on && v_disp_on;
    assign vretrace = vs_act;

    // R11
    retrace_track_chk: assert property (@(posedge clk) disable iff (rst)
        (vretrace != (vsync ^ cfg.vs_neg)) == 1'b0);

endmodule

// File: tb/crt_raster_gen_test.sv
module crt_raster_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic       hsync, vsync, hblank, vblank, disp_en, vretrace, line_cmp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    crt_raster_gen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
        .disp_en(disp_en), .vretrace(vretrace), .line_cmp(line_cmp)
    );

    typedef struct packed {
        logic [7:0]  i0, d0, i1, d1, i2, d2;
        logic [3:0]  sel;
        logic [3:0]  kind;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    // sel: 0 hsync 1 vsync 2 hblank 3 vblank 4 disp_en 5 vretrace 7 !hsync 8 !vsync
    // kind: 0 high width, 1 rise-to-rise period; index 8'hFF = no write
    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{8'hFF,8'd0,  8'hFF,8'd0, 8'hFF,8'd0,     4'd0,4'd1,16'd16,   8'd2},  // R2
        '{8'd0, 8'd27, 8'hFF,8'd0, 8'hFF,8'd0,     4'd0,4'd1,16'd32,   8'd2},  // R2
        '{8'hFF,8'd0,  8'hFF,8'd0, 8'hFF,8'd0,     4'd0,4'd0,16'd2,    8'd4},  // R4
        '{8'd0, 8'd43, 8'd4, 8'd3, 8'd5, 8'd3,     4'd0,4'd0,16'd32,   8'd4},  // R4 wrap
        '{8'd4, 8'd5,  8'd5, 8'd9, 8'hFF,8'd0,     4'd0,4'd0,16'd4,    8'd4},  // R4
        '{8'hFF,8'd0,  8'hFF,8'd0, 8'hFF,8'd0,     4'd2,4'd0,16'd6,    8'd5},  // R5
        '{8'd0, 8'd43, 8'd3, 8'd8, 8'd5, 8'h8D,    4'd2,4'd0,16'd31,   8'd5},  // R5 bit5
        '{8'hFF,8'd0,  8'hFF,8'd0, 8'hFF,8'd0,     4'd4,4'd0,16'd10,   8'd3},  // R3
        '{8'd1, 8'd4,  8'hFF,8'd0, 8'hFF,8'd0,     4'd4,4'd0,16'd5,    8'd3},  // R3
        '{8'hFF,8'd0,  8'hFF,8'd0, 8'hFF,8'd0,     4'd1,4'd1,16'd192,  8'd6},  // R6
        '{8'd6, 8'd0,  8'd7, 8'd1, 8'hFF,8'd0,     4'd1,4'd1,16'd4128, 8'd6},  // R6 ovf
        '{8'd15,8'd1,  8'hFF,8'd0, 8'hFF,8'd0,     4'd1,4'd1,16'd16576,8'd6},  // R6 ext
        '{8'hFF,8'd0,  8'hFF,8'd0, 8'hFF,8'd0,     4'd1,4'd0,16'd16,   8'd7},  // R7
        '{8'd10,8'd11, 8'hFF,8'd0, 8'hFF,8'd0,     4'd1,4'd0,16'd48,   8'd7},  // R7
        '{8'd6, 8'd30, 8'd10,8'd8, 8'hFF,8'd0,     4'd1,4'd0,16'd256,  8'd7},  // R7 wrap
        '{8'hFF,8'd0,  8'hFF,8'd0, 8'hFF,8'd0,     4'd3,4'd0,16'd64,   8'd8},  // R8
        '{8'd12,8'd4,  8'hFF,8'd0, 8'hFF,8'd0,     4'd3,4'd0,16'd112,  8'd8},  // R8
        '{8'd6, 8'd30, 8'd13,8'd31,8'hFF,8'd0,     4'd3,4'd0,16'd384,  8'd8},  // R8
        '{8'd16,8'h40, 8'hFF,8'd0, 8'hFF,8'd0,     4'd7,4'd0,16'd2,    8'd10}, // R10
        '{8'd16,8'h80, 8'hFF,8'd0, 8'hFF,8'd0,     4'd8,4'd0,16'd16,   8'd10}, // R10
        '{8'd16,8'h80, 8'hFF,8'd0, 8'hFF,8'd0,     4'd5,4'd0,16'd16,   8'd11}  // R11
    };

    function automatic logic sig(input int w);
        case (w)
            0: return hsync;
            1: return vsync;
            2: return hblank;
            3: return vblank;
            4: return disp_en;
            5: return vretrace;
            6: return line_cmp;
            7: return !hsync;
            8: return !vsync;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] idx, input logic [7:0] data);
        if (idx != 8'hFF) begin
            @(negedge clk);
            wr_en = 1'b1; wr_idx = idx[4:0]; wr_data = data;
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic wait_rise(input int w);
        @(negedge clk);
        while (sig(w)) @(negedge clk);
        while (!sig(w)) @(negedge clk);
    endtask

    task automatic high_len(input int w, output int n);
        wait_rise(w);
        n = 0;
        while (sig(w)) begin n++; @(negedge clk); end
    endtask

    task automatic period(input int w, output int n);
        wait_rise(w);
        n = 0;
        while (sig(w)) begin @(negedge clk); n++; end
        while (!sig(w)) begin @(negedge clk); n++; end
    endtask

    task automatic next_frames();
        wait_rise(1);
        wait_rise(1);
    endtask

    task automatic count_lc_frame(output int n);
        wait_rise(5);
        n = 0;
        @(negedge clk);
        while (!vretrace) begin if (line_cmp) n++; @(negedge clk); end
        while (vretrace) begin if (line_cmp) n++; @(negedge clk); end
        while (!vretrace) begin if (line_cmp) n++; @(negedge clk); end
    endtask

    initial begin
        int got;
        string tag;

        // R1 reset state
        do_reset();
        check("R1 hsync", int'(hsync), 0);
        check("R1 vsync", int'(vsync), 0);
        check("R1 hblank", int'(hblank), 0);
        check("R1 vblank", int'(vblank), 0);
        check("R1 disp_en", int'(disp_en), 1);
        check("R1 vretrace", int'(vretrace), 0);
        check("R1 line_cmp", int'(line_cmp), 0);
        period(0, got);
        check("R1 default line", got, 16);

        // vector table
        for (int v = 0; v < NV; v++) begin
            do_reset();
            write_reg(VECS[v].i0, VECS[v].d0);
            write_reg(VECS[v].i1, VECS[v].d1);
            write_reg(VECS[v].i2, VECS[v].d2);
            if (VECS[v].sel == 4'd8) begin
                wait_rise(8); wait_rise(8);
            end else begin
                next_frames();
            end
            if (VECS[v].kind == 4'd1) period(int'(VECS[v].sel), got);
            else high_len(int'(VECS[v].sel), got);
            tag = $sformatf("R%0d vector %0d", VECS[v].req, v);
            check(tag, got, int'(VECS[v].exp));
        end

        // R9 line compare: one pulse per frame at default, aligned with line 9, none when out of range
        do_reset();
        count_lc_frame(got);
        check("R9 pulses per frame", got, 1);
        write_reg(8'd14, 8'd9);
        next_frames();
        wait_rise(5);
        check("R9 pulse on line 9", int'(line_cmp), 1);
        write_reg(8'd14, 8'd200);
        next_frames();
        count_lc_frame(got);
        check("R9 unreachable compare", got, 0);

        // R12 write protect
        do_reset();
        write_reg(8'd10, 8'h89);
        write_reg(8'd0, 8'd27);
        write_reg(8'd14, 8'd9);
        next_frames();
        period(0, got);
        check("R12 protected total", got, 16);
        wait_rise(5);
        check("R12 unprotected index", int'(line_cmp), 1);
        write_reg(8'd10, 8'h09);
        write_reg(8'd0, 8'd27);
        next_frames();
        period(0, got);
        check("R12 after unprotect", got, 32);

        // R13 deferred update
        do_reset();
        wait_rise(5);
        write_reg(8'd0, 8'd27);
        period(0, got);
        check("R13 current frame", got, 16);
        next_frames();
        period(0, got);
        check("R13 next frame", got, 32);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule